// File: doc/BRIEF.md
# Fractional PLL Settings Register with Kick Handshake

This block holds the multiplier settings for one fractional-N PLL behind a small synchronous register port. Software stages an integer multiplier, an optional fractional multiplier and spread-spectrum controls. It then sets a kick bit in the first control word. The block treats the kick as a relock request. It drops the PLL's lock indication in a shared status word and runs a relock timer whose length is a parameter. When the timer expires, the block copies the staged settings to its active outputs, clears the kick bit and raises the lock indication again.

The analog loop itself is not modelled. The block exposes the effective multiplication as a fixed-point word with 24 fraction bits. Downstream clock logic, or a rate monitor, can consume that word directly. The lock indication sits in a status word shared with other PLLs, so its bit position depends on which PLL this instance serves.

Top module: `pll_kick_regs`

## Requirements
- R1: After reset, control word 0 (word index 0) and control word 1 (word index 1) read as zero, the PLL's status bit reads 1, and the effective multiplication output equals 2.0 (value 2<<24).
- R2: Control word 0 holds the kick at bit 31, the integer field at bits 27:20, the fractional enable at bit 18, dithering at bit 17, centre spread at bit 16, the modulation rate at bits 14:8 and the modulation depth at bits 6:0. All other bits read as zero.
- R3: Control word 1 holds a 25-bit fractional field at bits 24:0. Bits 31:25 read as zero.
- R4: A write to control word 0 with bit 31 set, made while no kick is pending, sets the kick bit and clears the PLL's status bit in the following cycle.
- R5: The kick bit clears and the status bit rises exactly RELOCK_CYCLES clock edges after the edge that accepted the kick, and not earlier.
- R6: While a kick is pending, writes to either control word, including a further kick, are refused. Read-back is unchanged, and the pending relock keeps its original end time.
- R7: The active setting outputs and the effective multiplication change only at relock completion. Writes without a kick alter only the staged values.
- R8: The effective multiplication equals ((integer field + 1) × 2) << 24, plus the fractional field when fractional mode is enabled. With fractional mode off, the fractional field has no effect.
- R9: The status word (word index 2) has at most one bit set. For PLL n that bit is 8+n−1 when n<3, 8+n when n=3, and 8+n+1 when n>3.
- R10: Reads return data one cycle after the request with a valid strobe, and word index 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Word index of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Word index of the read |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data |
| act_int_mult | output | 8 | Active integer multiplier field |
| act_frac_en | output | 1 | Active fractional enable |
| act_frac | output | 25 | Active fractional field |
| act_spread_mode | output | 3 | Active spread mode {fractional, dither, centre} |
| act_mod_rate | output | 7 | Active modulation rate |
| act_mod_depth | output | 7 | Active modulation depth |
| eff_mult | output | 34 | Effective multiplication, 24 fraction bits |

## Verification
The hardest case to reach is a write that arrives while a relock is already counting, particularly one that carries a second kick. The refusal of such a write only shows up as the absence of a change. The stimulus issues the kick and then, on the next two edges, writes both control words, one of them with the kick bit set. It then reads the status word on every edge around the expected end. This shows that the relock neither restarted nor finished early, and that the refused values never reached the active outputs.

// File: rtl/pll_kick_pkg.sv
package pll_kick_pkg;

  localparam int REG_W     = 32;
  localparam int IDX_W     = 2;
  localparam int KICK_BIT  = 31;
  localparam int NI_LSB    = 20;
  localparam int NI_W      = 8;
  localparam int FM_BIT    = 18;
  localparam int DITH_BIT  = 17;
  localparam int CENT_BIT  = 16;
  localparam int RATE_LSB  = 8;
  localparam int RATE_W    = 7;
  localparam int DEPTH_LSB = 0;
  localparam int DEPTH_W   = 7;
  localparam int NF_W      = 25;
  localparam int FRAC_SH   = 24;
  localparam int MULT_W    = NI_W + 2 + FRAC_SH;

  typedef enum logic [IDX_W-1:0] {
    SEL_CTRL0  = 2'd0,
    SEL_CTRL1  = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [NI_W-1:0]    ni;
    logic               fm;
    logic               dith;
    logic               cent;
    logic [RATE_W-1:0]  rate;
    logic [DEPTH_W-1:0] depth;
    logic [NF_W-1:0]    nf;
  } pll_cfg_t;

  // Position of a PLL's lock bit in the shared status word.
  function automatic int status_bit(input int n);
    if (n < 3)       return 8 + n - 1;
    else if (n == 3) return 8 + n;
    else             return 8 + n + 1;
  endfunction

endpackage

// File: rtl/pll_cfg_stage.sv
module pll_cfg_stage
  import pll_kick_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  reg_sel_e         wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             busy_i,
  output pll_cfg_t         cfg_o,
  output logic             kick_req_o
);

  pll_cfg_t cfg_q;
  logic     accept;
  logic     unused_bits;

  assign accept      = wr_en && !busy_i;
  assign unused_bits = ^{wr_data[30:28], wr_data[19], wr_data[15], wr_data[7]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (accept) begin
      case (wr_sel)
        SEL_CTRL0: begin
          cfg_q.ni    <= wr_data[NI_LSB +: NI_W];
          cfg_q.fm    <= wr_data[FM_BIT];
          cfg_q.dith  <= wr_data[DITH_BIT];
          cfg_q.cent  <= wr_data[CENT_BIT];
          cfg_q.rate  <= wr_data[RATE_LSB +: RATE_W];
          cfg_q.depth <= wr_data[DEPTH_LSB +: DEPTH_W];
        end
        SEL_CTRL1: cfg_q.nf <= wr_data[NF_W-1:0];
        default: ;
      endcase
    end
  end

  assign kick_req_o = accept && (wr_sel == SEL_CTRL0) && wr_data[KICK_BIT];
  assign cfg_o      = cfg_q;

  AST_STAGE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> $stable(cfg_q)); // R6

endmodule

// File: rtl/pll_relock_timer.sv
module pll_relock_timer #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic kick_req_i,
  output logic busy_o,
  output logic locked_o,
  output logic done_o
);

  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             kick_q;
  logic             lock_q;

  initial begin
    AST_CYCLES_VALID: assert (CYCLES >= 1); // R5
  end

  assign done_o = kick_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      kick_q <= 1'b0;
      lock_q <= 1'b1;
    end else if (kick_q) begin
      if (cnt_q == '0) begin
        kick_q <= 1'b0;
        lock_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (kick_req_i) begin
      kick_q <= 1'b1;
      lock_q <= 1'b0;
      cnt_q  <= CNT_LOAD;
    end
  end

  assign busy_o   = kick_q;
  assign locked_o = lock_q;

  AST_LOCK_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q) |-> ($past(kick_q) && !kick_q)); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_LOAD); // R5
  AST_KICK_DROPS_LOCK: assert property (@(posedge clk) disable iff (rst)
    (kick_req_i && !kick_q) |=> (kick_q && !lock_q)); // R4

endmodule

// File: rtl/pll_mult_calc.sv
module pll_mult_calc
  import pll_kick_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  pll_cfg_t          cfg_i,
  output pll_cfg_t          act_o,
  output logic [MULT_W-1:0] mult_o
);

  localparam logic [MULT_W-1:0] MULT_RST = MULT_W'(1) << (FRAC_SH + 1);

  pll_cfg_t          act_q;
  logic [MULT_W-1:0] mult_q;
  logic [MULT_W-1:0] int_part;
  logic [MULT_W-1:0] frac_part;

  always_comb begin
    int_part  = (MULT_W'(cfg_i.ni) + MULT_W'(1)) << (FRAC_SH + 1);
    frac_part = cfg_i.fm ? MULT_W'(cfg_i.nf) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= '0;
      mult_q <= MULT_RST;
    end else if (done_i) begin
      act_q  <= cfg_i;
      mult_q <= int_part + frac_part;
    end
  end

  assign act_o  = act_q;
  assign mult_o = mult_q;

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_i |=> ($stable(act_q) && $stable(mult_q))); // R7
  AST_NO_FRAC_OFF: assert property (@(posedge clk) disable iff (rst)
    !act_q.fm |-> (mult_q[FRAC_SH-1:0] == '0)); // R8
  AST_INT_FLOOR: assert property (@(posedge clk) disable iff (rst)
    mult_q[MULT_W-1:FRAC_SH] >= ((MULT_W-FRAC_SH)'(act_q.ni) + 1'b1) * 2); // R8

endmodule

// File: rtl/pll_kick_regs.sv
module pll_kick_regs
  import pll_kick_pkg::*;
#(
  parameter int PLL_INDEX     = 1,
  parameter int RELOCK_CYCLES = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [31:0]          wr_data,
  input  logic                 rd_en,
  input  logic [1:0]           rd_addr,
  output logic                 rd_valid,
  output logic [31:0]          rd_data,
  output logic [7:0]           act_int_mult,
  output logic                 act_frac_en,
  output logic [24:0]          act_frac,
  output logic [2:0]           act_spread_mode,
  output logic [6:0]           act_mod_rate,
  output logic [6:0]           act_mod_depth,
  output logic [33:0]          eff_mult
);

  localparam int STAT_IDX = status_bit(PLL_INDEX);

  pll_cfg_t          cfg_s;
  pll_cfg_t          act_s;
  logic              kick_req;
  logic              busy;
  logic              locked;
  logic              done;
  logic [REG_W-1:0]  ctrl0_w;
  logic [REG_W-1:0]  ctrl1_w;
  logic [REG_W-1:0]  status_w;
  logic [REG_W-1:0]  rd_next;
  logic [REG_W-1:0]  rd_q;
  logic              rd_v_q;
  logic [MULT_W-1:0] mult_s;

  initial begin
    AST_INDEX_RANGE: assert (PLL_INDEX >= 1 && STAT_IDX < REG_W); // R9
  end

  pll_cfg_stage u_stage (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (reg_sel_e'(wr_addr)),
    .wr_data    (wr_data),
    .busy_i     (busy),
    .cfg_o      (cfg_s),
    .kick_req_o (kick_req)
  );

  pll_relock_timer #(.CYCLES(RELOCK_CYCLES)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .kick_req_i (kick_req),
    .busy_o     (busy),
    .locked_o   (locked),
    .done_o     (done)
  );

  pll_mult_calc u_calc (
    .clk    (clk),
    .rst    (rst),
    .done_i (done),
    .cfg_i  (cfg_s),
    .act_o  (act_s),
    .mult_o (mult_s)
  );

  always_comb begin
    ctrl0_w                            = '0;
    ctrl0_w[KICK_BIT]                  = busy;
    ctrl0_w[NI_LSB +: NI_W]            = cfg_s.ni;
    ctrl0_w[FM_BIT]                    = cfg_s.fm;
    ctrl0_w[DITH_BIT]                  = cfg_s.dith;
    ctrl0_w[CENT_BIT]                  = cfg_s.cent;
    ctrl0_w[RATE_LSB +: RATE_W]        = cfg_s.rate;
    ctrl0_w[DEPTH_LSB +: DEPTH_W]      = cfg_s.depth;
    ctrl1_w                            = '0;
    ctrl1_w[NF_W-1:0]                  = cfg_s.nf;
  end

  for (genvar b = 0; b < REG_W; b++) begin : g_stat
    if (b == STAT_IDX) begin : g_lock
      assign status_w[b] = locked;
    end else begin : g_zero
      assign status_w[b] = 1'b0;
    end
  end

  always_comb begin
    case (reg_sel_e'(rd_addr))
      SEL_CTRL0:  rd_next = ctrl0_w;
      SEL_CTRL1:  rd_next = ctrl1_w;
      SEL_STATUS: rd_next = status_w;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= '0;
      rd_v_q <= 1'b0;
    end else begin
      rd_v_q <= rd_en;
      if (rd_en) rd_q <= rd_next;
    end
  end

  assign rd_valid        = rd_v_q;
  assign rd_data         = rd_q;
  assign act_int_mult    = act_s.ni;
  assign act_frac_en     = act_s.fm;
  assign act_frac        = act_s.nf;
  assign act_spread_mode = {act_s.fm, act_s.dith, act_s.cent};
  assign act_mod_rate    = act_s.rate;
  assign act_mod_depth   = act_s.depth;
  assign eff_mult        = mult_s;

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_v_q |-> $past(rd_en)); // R10
  AST_STATUS_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (rd_v_q && $past(rd_addr) == 2'd2) |-> $onehot0(rd_q)); // R9
  AST_LOCK_VS_KICK: assert property (@(posedge clk) disable iff (rst)
    (rd_v_q && $past(rd_addr) == 2'd0 && $past(locked)) |-> !rd_q[KICK_BIT]); // R4

endmodule

// File: tb/pll_kick_regs_tb.sv
module pll_kick_regs_tb;

  localparam int NPLL   = 4;
  localparam int RELOCK = 8;
  localparam logic [31:0] LOCKBIT = 32'h1 << 13;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en, rd_valid;
  logic [1:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [7:0]  act_int_mult;
  logic        act_frac_en;
  logic [24:0] act_frac;
  logic [2:0]  act_spread_mode;
  logic [6:0]  act_mod_rate, act_mod_depth;
  logic [33:0] eff_mult;

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  pll_kick_regs #(.PLL_INDEX(NPLL), .RELOCK_CYCLES(RELOCK)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .act_int_mult(act_int_mult), .act_frac_en(act_frac_en), .act_frac(act_frac),
    .act_spread_mode(act_spread_mode), .act_mod_rate(act_mod_rate),
    .act_mod_depth(act_mod_depth), .eff_mult(eff_mult)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Each task starts at a falling edge and consumes one rising edge.
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard whenever read data comes back.
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R10 unexpected read data actual=%0h expected=none", rd_data);
      end else begin
        logic [31:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(64'(rd_data), 64'(e), t);
      end
    end
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    idle(3);
    rst = 1'b0;

    // R1 reset state
    rd(2'd0, 32'h0, "R1 ctrl0 reset");
    rd(2'd1, 32'h0, "R1 ctrl1 reset");
    rd(2'd2, LOCKBIT, "R1 R9 status reset");
    chk(64'(eff_mult), 64'h0200_0000, "R1 eff_mult reset");
    chk(64'(act_int_mult), 64'h0, "R1 act_int_mult reset");

    // R2 R3 field layout, unused bits zero; R7 no kick leaves active alone
    wr(2'd0, 32'h7FFF_FFFF);
    rd(2'd0, 32'h0FF7_7F7F, "R2 ctrl0 layout");
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'h01FF_FFFF, "R3 ctrl1 layout");
    chk(64'(eff_mult), 64'h0200_0000, "R7 active untouched by plain writes");
    rd(2'd3, 32'h0, "R10 unused word");

    // Fractional kick: ni=5, fm, dither, rate 0x12, depth 5, nf=2^23
    wr(2'd1, 32'h0080_0000);
    wr(2'd0, 32'h8056_1205);            // edge E0
    wr(2'd0, 32'h8010_0000);            // E1 refused, carries kick
    wr(2'd1, 32'h0000_0000);            // E2 refused
    rd(2'd2, 32'h0, "R4 status drops after kick");        // E3
    rd(2'd0, 32'h8056_1205, "R4 R6 ctrl0 kick set, write refused"); // E4
    rd(2'd1, 32'h0080_0000, "R6 ctrl1 write refused");    // E5
    chk(64'(act_int_mult), 64'h0, "R7 active held during relock");
    rd(2'd2, 32'h0, "R5 not done E6");
    rd(2'd2, 32'h0, "R5 not done E7");
    rd(2'd2, 32'h0, "R5 R6 not done E8");                 // completion edge
    chk(64'(act_int_mult), 64'h5, "R7 active ni at completion");
    chk(64'(eff_mult), 64'h0C80_0000, "R8 fractional multiplication");
    chk(64'(act_spread_mode), 64'h6, "R7 spread mode");
    chk(64'(act_mod_rate), 64'h12, "R7 modulation rate");
    chk(64'(act_mod_depth), 64'h05, "R7 modulation depth");
    rd(2'd2, LOCKBIT, "R5 R9 status back");               // E9
    rd(2'd0, 32'h0056_1205, "R5 kick self-cleared");

    // Integer-only kick: nf stays staged but must not count
    wr(2'd0, 32'h8FF0_0000);
    idle(RELOCK);
    chk(64'(eff_mult), 64'h2_0000_0000, "R8 fraction ignored when disabled");
    chk(64'(act_frac_en), 64'h0, "R8 fractional enable off");
    rd(2'd2, LOCKBIT, "R5 second relock done");

    idle(3);
    chk(64'(exp_q.size()), 64'h0, "R10 all reads answered");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule